// File: doc/BRIEF.md
# Write-channel demultiplexer with counter-based W steering

The block takes one upstream write port (address, data and response channels) and fans it out to a parameterised number of downstream write ports. A port index comes with every address beat. The block forwards each address beat to the port that index names. It then routes the data beats that follow to that same port.

W routing needs no queue between the address and data channels. Routing state is one register that holds the most recent port index and a counter of accepted address beats whose data bursts have not yet finished. A new address beat that targets a different port therefore waits until every earlier data burst has drained. As a result, data beats for two ports are never interleaved, and downstream ports cannot form a circular wait on each other's data.

A table indexed by the low bits of the write ID keeps, for each ID value, an outstanding count and the port in use. An ID is never live at two ports at once, so responses for one ID cannot return out of order. Responses from the downstream ports are merged upstream by a round-robin arbiter. The arbiter holds its choice until the upstream side accepts the response.

Top module: `aw_steer_demux`

## Requirements
- R1: An accepted address beat is presented to exactly the downstream port given by `up_aw_sel_i`, with ID, address and length unchanged, and to no other port in that cycle.
- R2: Every data beat reaches only the port of the address beat it belongs to, in address-acceptance order. Each port receives exactly the sum of (length+1) beats over the address beats sent to it. No downstream data valid is raised while no burst is open.
- R3: While any earlier data burst is still open, an address beat whose port differs from the port of the last accepted address beat is not accepted. An address beat to the same port may be accepted.
- R4: The open-burst counter is OPEN_W bits wide, OPEN_W = clog2(MAX_TRANS+1), which is 4 for the defaults. While it holds all ones (15), no address beat is accepted. An address beat and a final data beat in the same cycle leave it unchanged.
- R5: An address beat is not accepted while its ID entry already counts MAX_TRANS (8) outstanding writes. It is accepted once a response for that ID has returned.
- R6: An address beat whose ID entry has writes outstanding at another port waits until those responses return. One to the same port, or with an ID that has nothing outstanding, proceeds.
- R7: The ID table is indexed by only the low ID_USED bits (2) of the ID. IDs 1 and 5 share one entry.
- R8: Each downstream response reaches the upstream port with its ID and response code. When several ports hold responses, they are granted in round-robin order, so two ports that both stay valid alternate.
- R9: Once the upstream response valid is raised, it stays high with a stable ID until it is accepted.
- R10: After reset, no downstream address or data valid, no upstream response valid and no upstream data ready is raised until stimulus arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_aw_valid_i | input | 1 | Upstream address valid |
| up_aw_ready_o | output | 1 | Upstream address ready |
| up_aw_id_i | input | ID_W | Write ID |
| up_aw_addr_i | input | ADDR_W | Write address |
| up_aw_len_i | input | LEN_W | Burst length minus one |
| up_aw_sel_i | input | SEL_W | Target downstream port index |
| up_w_valid_i | input | 1 | Upstream data valid |
| up_w_ready_o | output | 1 | Upstream data ready |
| up_w_data_i | input | DATA_W | Write data |
| up_w_last_i | input | 1 | Final beat of burst |
| up_b_valid_o | output | 1 | Upstream response valid |
| up_b_ready_i | input | 1 | Upstream response ready |
| up_b_id_o | output | ID_W | Response ID |
| up_b_resp_o | output | 2 | Response code |
| dn_aw_valid_o | output | NUM_PORTS | Per-port address valid |
| dn_aw_ready_i | input | NUM_PORTS | Per-port address ready |
| dn_aw_id_o | output | ID_W | Broadcast address ID |
| dn_aw_addr_o | output | ADDR_W | Broadcast address |
| dn_aw_len_o | output | LEN_W | Broadcast length |
| dn_w_valid_o | output | NUM_PORTS | Per-port data valid |
| dn_w_ready_i | input | NUM_PORTS | Per-port data ready |
| dn_w_data_o | output | DATA_W | Broadcast data |
| dn_w_last_o | output | 1 | Broadcast last flag |
| dn_b_valid_i | input | NUM_PORTS | Per-port response valid |
| dn_b_ready_o | output | NUM_PORTS | Per-port response ready |
| dn_b_id_i | input | NUM_PORTS x ID_W | Per-port response ID |
| dn_b_resp_i | input | NUM_PORTS x 2 | Per-port response code |

## Verification
The bench fills the open-burst counter to fifteen while data is held back. A design that wraps the counter instead of stalling would send a sixteenth address beat and lose track of which port later data belongs to. It then sends an address beat to a new port while a burst is still open and checks that it stalls: without this, beats for two ports would interleave. It also fills one ID entry to its limit and reuses an ID at a different port. An alias ID (5 against 1) must also hit the shared entry. A table that over-counted, or that looked up all ID bits, would accept those address beats and allow responses for one ID to arrive out of order. Random traffic checks every data beat against the port of its address beat and checks per-port beat totals. Directed response backlogs check that the round-robin arbiter alternates and holds its choice.

// File: rtl/aw_steer_pkg.sv
package aw_steer_pkg;
  typedef logic [1:0] bresp_t;

  function automatic int unsigned sel_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wr_id_table.sv
module wr_id_table #(
  parameter int unsigned ID_USED   = 2,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned MAX_TRANS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_TRANS + 1),
  localparam int unsigned ENTRIES  = 1 << ID_USED
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ID_USED-1:0] look_id_i,
  input  logic [SEL_W-1:0]   look_sel_i,
  output logic               pass_o,
  input  logic               alloc_i,
  input  logic [ID_USED-1:0] alloc_id_i,
  input  logic [SEL_W-1:0]   alloc_sel_i,
  input  logic               free_i,
  input  logic [ID_USED-1:0] free_id_i
);
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;
  logic [ENTRIES-1:0][SEL_W-1:0] port_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : gen_entry
    logic inc, dec;
    assign inc = alloc_i && (alloc_id_i == ID_USED'(e));
    assign dec = free_i  && (free_id_i  == ID_USED'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[e]  <= '0;
        port_q[e] <= '0;
      end else begin
        if (inc && !dec)      cnt_q[e] <= cnt_q[e] + 1'b1;
        else if (dec && !inc) cnt_q[e] <= cnt_q[e] - 1'b1;
        if (inc) port_q[e] <= alloc_sel_i;
      end
    end
  end

  // full entry blocks; a live entry only admits its own port
  assign pass_o = (cnt_q[look_id_i] != CNT_W'(MAX_TRANS)) &&
                  ((cnt_q[look_id_i] == '0) || (port_q[look_id_i] == look_sel_i));
endmodule

// File: rtl/wr_w_steer.sv
module wr_w_steer #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned OPEN_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 aw_hs_i,
  input  logic [SEL_W-1:0]     aw_sel_i,
  input  logic                 up_w_valid_i,
  input  logic                 up_w_last_i,
  output logic                 up_w_ready_o,
  output logic [NUM_PORTS-1:0] dn_w_valid_o,
  input  logic [NUM_PORTS-1:0] dn_w_ready_i,
  output logic [SEL_W-1:0]     w_sel_o,
  output logic                 open_idle_o,
  output logic                 open_full_o
);
  logic [OPEN_W-1:0] open_q;
  logic [SEL_W-1:0]  sel_q;
  logic              w_active, w_done;

  assign w_active     = (open_q != '0);
  assign up_w_ready_o = w_active && dn_w_ready_i[sel_q];
  assign w_done       = up_w_valid_i && up_w_ready_o && up_w_last_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gen_wv
    assign dn_w_valid_o[p] = w_active && up_w_valid_i && (sel_q == SEL_W'(p));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      sel_q  <= '0;
    end else begin
      if (aw_hs_i && !w_done)      open_q <= open_q + 1'b1;
      else if (w_done && !aw_hs_i) open_q <= open_q - 1'b1;
      if (aw_hs_i) sel_q <= aw_sel_i;
    end
  end

  assign w_sel_o     = sel_q;
  assign open_idle_o = !w_active;
  assign open_full_o = &open_q;
endmodule

// File: rtl/wr_b_arb.sv
module wr_b_arb
  import aw_steer_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned ID_W      = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS-1:0]           dn_b_valid_i,
  output logic [NUM_PORTS-1:0]           dn_b_ready_o,
  input  logic [NUM_PORTS-1:0][ID_W-1:0] dn_b_id_i,
  input  bresp_t [NUM_PORTS-1:0]         dn_b_resp_i,
  output logic                           up_b_valid_o,
  input  logic                           up_b_ready_i,
  output logic [ID_W-1:0]                up_b_id_o,
  output bresp_t                         up_b_resp_o
);
  logic [SEL_W-1:0] ptr_q, lock_idx_q, pick, grant;
  logic             lock_q, found;
  int unsigned      scan;

  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    scan  = 0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      scan = int'(ptr_q) + k;
      if (scan >= NUM_PORTS) scan = scan - NUM_PORTS;
      if (!found && dn_b_valid_i[scan]) begin
        pick  = SEL_W'(scan);
        found = 1'b1;
      end
    end
  end

  // held grant keeps an unaccepted response stable
  assign grant        = lock_q ? lock_idx_q : pick;
  assign up_b_valid_o = lock_q ? dn_b_valid_i[lock_idx_q] : found;
  assign up_b_id_o    = dn_b_id_i[grant];
  assign up_b_resp_o  = dn_b_resp_i[grant];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gen_br
    assign dn_b_ready_o[p] = up_b_ready_i && (grant == SEL_W'(p));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else if (up_b_valid_o && up_b_ready_i) begin
      ptr_q  <= (grant == SEL_W'(NUM_PORTS - 1)) ? '0 : grant + 1'b1;
      lock_q <= 1'b0;
    end else if (up_b_valid_o) begin
      lock_q     <= 1'b1;
      lock_idx_q <= grant;
    end
  end
endmodule

// File: rtl/aw_steer_demux.sv
module aw_steer_demux
  import aw_steer_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ID_USED   = 2,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned MAX_TRANS = 8,
  localparam int unsigned SEL_W    = sel_width(NUM_PORTS),
  localparam int unsigned OPEN_W   = $clog2(MAX_TRANS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           up_aw_valid_i,
  output logic                           up_aw_ready_o,
  input  logic [ID_W-1:0]                up_aw_id_i,
  input  logic [ADDR_W-1:0]              up_aw_addr_i,
  input  logic [LEN_W-1:0]               up_aw_len_i,
  input  logic [SEL_W-1:0]               up_aw_sel_i,
  input  logic                           up_w_valid_i,
  output logic                           up_w_ready_o,
  input  logic [DATA_W-1:0]              up_w_data_i,
  input  logic                           up_w_last_i,
  output logic                           up_b_valid_o,
  input  logic                           up_b_ready_i,
  output logic [ID_W-1:0]                up_b_id_o,
  output logic [1:0]                     up_b_resp_o,
  output logic [NUM_PORTS-1:0]           dn_aw_valid_o,
  input  logic [NUM_PORTS-1:0]           dn_aw_ready_i,
  output logic [ID_W-1:0]                dn_aw_id_o,
  output logic [ADDR_W-1:0]              dn_aw_addr_o,
  output logic [LEN_W-1:0]               dn_aw_len_o,
  output logic [NUM_PORTS-1:0]           dn_w_valid_o,
  input  logic [NUM_PORTS-1:0]           dn_w_ready_i,
  output logic [DATA_W-1:0]              dn_w_data_o,
  output logic                           dn_w_last_o,
  input  logic [NUM_PORTS-1:0]           dn_b_valid_i,
  output logic [NUM_PORTS-1:0]           dn_b_ready_o,
  input  logic [NUM_PORTS-1:0][ID_W-1:0] dn_b_id_i,
  input  logic [NUM_PORTS-1:0][1:0]      dn_b_resp_i
);
  logic             id_pass, open_idle, open_full, aw_allow, aw_hs;
  logic [SEL_W-1:0] w_sel;

  assign aw_allow = id_pass && !open_full && (open_idle || (w_sel == up_aw_sel_i));
  assign up_aw_ready_o = aw_allow && dn_aw_ready_i[up_aw_sel_i];
  assign aw_hs = up_aw_valid_i && up_aw_ready_o;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gen_awv
    assign dn_aw_valid_o[p] = up_aw_valid_i && aw_allow && (up_aw_sel_i == SEL_W'(p));
  end

  assign dn_aw_id_o   = up_aw_id_i;
  assign dn_aw_addr_o = up_aw_addr_i;
  assign dn_aw_len_o  = up_aw_len_i;
  assign dn_w_data_o  = up_w_data_i;
  assign dn_w_last_o  = up_w_last_i;

  wr_id_table #(
    .ID_USED(ID_USED), .SEL_W(SEL_W), .MAX_TRANS(MAX_TRANS)
  ) u_id_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_id_i  (up_aw_id_i[ID_USED-1:0]),
    .look_sel_i (up_aw_sel_i),
    .pass_o     (id_pass),
    .alloc_i    (aw_hs),
    .alloc_id_i (up_aw_id_i[ID_USED-1:0]),
    .alloc_sel_i(up_aw_sel_i),
    .free_i     (up_b_valid_o && up_b_ready_i),
    .free_id_i  (up_b_id_o[ID_USED-1:0])
  );

  wr_w_steer #(
    .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W), .OPEN_W(OPEN_W)
  ) u_w_steer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .aw_hs_i     (aw_hs),
    .aw_sel_i    (up_aw_sel_i),
    .up_w_valid_i(up_w_valid_i),
    .up_w_last_i (up_w_last_i),
    .up_w_ready_o(up_w_ready_o),
    .dn_w_valid_o(dn_w_valid_o),
    .dn_w_ready_i(dn_w_ready_i),
    .w_sel_o     (w_sel),
    .open_idle_o (open_idle),
    .open_full_o (open_full)
  );

  wr_b_arb #(
    .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W), .ID_W(ID_W)
  ) u_b_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dn_b_valid_i(dn_b_valid_i),
    .dn_b_ready_o(dn_b_ready_o),
    .dn_b_id_i   (dn_b_id_i),
    .dn_b_resp_i (dn_b_resp_i),
    .up_b_valid_o(up_b_valid_o),
    .up_b_ready_i(up_b_ready_i),
    .up_b_id_o   (up_b_id_o),
    .up_b_resp_o (up_b_resp_o)
  );
endmodule

// File: rtl/aw_steer_checks.sv
module aw_steer_checks #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned OPEN_W    = 4,
  parameter int unsigned ID_W      = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 up_aw_valid_i,
  input logic                 up_aw_ready_o,
  input logic [SEL_W-1:0]     up_aw_sel_i,
  input logic                 up_w_valid_i,
  input logic                 up_w_ready_o,
  input logic                 up_w_last_i,
  input logic [NUM_PORTS-1:0] dn_aw_valid_o,
  input logic [NUM_PORTS-1:0] dn_w_valid_o,
  input logic                 up_b_valid_o,
  input logic                 up_b_ready_i,
  input logic [ID_W-1:0]      up_b_id_o
);
  logic [OPEN_W-1:0] sh_open;
  logic [SEL_W-1:0]  sh_sel;
  logic              aw_hs, w_done;

  assign aw_hs  = up_aw_valid_i && up_aw_ready_o;
  assign w_done = up_w_valid_i && up_w_ready_o && up_w_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_open <= '0;
      sh_sel  <= '0;
    end else begin
      if (aw_hs && !w_done)      sh_open <= sh_open + 1'b1;
      else if (w_done && !aw_hs) sh_open <= sh_open - 1'b1;
      if (aw_hs) sh_sel <= up_aw_sel_i;
    end
  end

  assert_aw_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dn_aw_valid_o));
  assert_aw_port_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_hs |-> dn_aw_valid_o[up_aw_sel_i]);
  assert_w_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dn_w_valid_o));
  assert_w_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_open != '0 && up_w_valid_i) |-> dn_w_valid_o[sh_sel]);
  assert_w_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_open == '0) |-> (dn_w_valid_o == '0));
  assert_cross_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_open != '0 && up_aw_valid_i && up_aw_sel_i != sh_sel) |-> !up_aw_ready_o);
  assert_open_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&sh_open) |-> !up_aw_ready_o);
  assert_b_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_b_valid_o && !up_b_ready_i) |=> (up_b_valid_o && $stable(up_b_id_o)));
endmodule

bind aw_steer_demux aw_steer_checks #(
  .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W), .OPEN_W(OPEN_W), .ID_W(ID_W)
) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .up_aw_valid_i(up_aw_valid_i),
  .up_aw_ready_o(up_aw_ready_o),
  .up_aw_sel_i  (up_aw_sel_i),
  .up_w_valid_i (up_w_valid_i),
  .up_w_ready_o (up_w_ready_o),
  .up_w_last_i  (up_w_last_i),
  .dn_aw_valid_o(dn_aw_valid_o),
  .dn_w_valid_o (dn_w_valid_o),
  .up_b_valid_o (up_b_valid_o),
  .up_b_ready_i (up_b_ready_i),
  .up_b_id_o    (up_b_id_o)
);

// File: tb/aw_steer_demux_bench.sv
module aw_steer_demux_bench;
  localparam int NP = 4;
  localparam int IDW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic up_aw_valid_i = 0, up_aw_ready_o;
  logic [IDW-1:0] up_aw_id_i = 0;
  logic [31:0] up_aw_addr_i = 0;
  logic [7:0] up_aw_len_i = 0;
  logic [1:0] up_aw_sel_i = 0;
  logic up_w_valid_i = 0, up_w_ready_o, up_w_last_i = 0;
  logic [31:0] up_w_data_i = 0;
  logic up_b_valid_o, up_b_ready_i = 0;
  logic [IDW-1:0] up_b_id_o;
  logic [1:0] up_b_resp_o;
  logic [NP-1:0] dn_aw_valid_o, dn_aw_ready_i = 0;
  logic [IDW-1:0] dn_aw_id_o;
  logic [31:0] dn_aw_addr_o;
  logic [7:0] dn_aw_len_o;
  logic [NP-1:0] dn_w_valid_o, dn_w_ready_i = 0;
  logic [31:0] dn_w_data_o;
  logic dn_w_last_o;
  logic [NP-1:0] dn_b_valid_i = 0, dn_b_ready_o;
  logic [NP-1:0][IDW-1:0] dn_b_id_i = 0;
  logic [NP-1:0][1:0] dn_b_resp_i = 0;

  aw_steer_demux u_aw_steer_demux (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  // stimulus knobs
  bit aw_pend = 0, rand_on = 0, w_go = 1, b_go = 1;
  int aw_pct = 100, wr_pct = 100, ub_pct = 100, w_pct = 100, braise_pct = 100;
  logic [IDW-1:0] n_id; logic [1:0] n_sel; logic [7:0] n_len;
  // models
  int wlen_q[$], wport_q[$], awid_q[NP][$], bq[NP][$], bseq[$];
  int out_cnt[16], exp_beats[NP], got_beats[NP];
  int w_beat = 0, in_beat = 0;
  bit w_v = 0, prev_wait = 0;
  bit b_v[NP];
  logic [IDW-1:0] prev_id;

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  // per-cycle engine: drive at negedge, sample 2 ns before posedge
  initial begin
    void'($urandom(32'd2718));
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (rand_on && !aw_pend && pct(40)) begin
        n_id = IDW'($urandom % 16); n_sel = 2'($urandom % NP); n_len = 8'($urandom % 4);
        aw_pend = 1;
      end
      up_aw_valid_i = aw_pend; up_aw_id_i = n_id; up_aw_sel_i = n_sel;
      up_aw_len_i = n_len; up_aw_addr_i = {24'h0, n_id, 2'b0, n_sel};
      if (wlen_q.size() > 0 && w_go && !w_v && pct(w_pct)) w_v = 1;
      up_w_valid_i = w_v;
      up_w_last_i = (wlen_q.size() > 0) && (w_beat == wlen_q[0]);
      up_w_data_i = 32'(w_beat);
      for (int p = 0; p < NP; p++) begin
        dn_aw_ready_i[p] = pct(aw_pct);
        dn_w_ready_i[p] = pct(wr_pct);
        if (!b_v[p] && b_go && bq[p].size() > 0 && pct(braise_pct)) b_v[p] = 1;
        dn_b_valid_i[p] = b_v[p];
        dn_b_id_i[p] = (bq[p].size() > 0) ? IDW'(bq[p][0]) : '0;
        dn_b_resp_i[p] = dn_b_id_i[p][1:0];
      end
      up_b_ready_i = pct(ub_pct);
      #8;
      if (up_aw_valid_i && up_aw_ready_o) begin
        check(dn_aw_valid_o == NP'(1 << n_sel) && dn_aw_id_o == n_id && dn_aw_len_o == n_len,
              "R1 aw routing", int'(dn_aw_valid_o), 1 << n_sel);
        wlen_q.push_back(int'(n_len)); wport_q.push_back(int'(n_sel));
        awid_q[n_sel].push_back(int'(n_id));
        out_cnt[n_id]++; exp_beats[n_sel] += int'(n_len) + 1;
        aw_pend = 0;
      end
      if (wport_q.size() == 0)
        check(dn_w_valid_o == '0, "R2 w idle", int'(dn_w_valid_o), 0);
      for (int p = 0; p < NP; p++) begin
        if (dn_w_valid_o[p] && dn_w_ready_i[p]) begin
          check(wport_q.size() > 0 && wport_q[0] == p, "R2 w port",
                p, (wport_q.size() > 0) ? wport_q[0] : -1);
          got_beats[p]++;
          if (dn_w_last_o) begin
            check(in_beat == wlen_q[0], "R2 burst len", in_beat, wlen_q[0]);
            bq[p].push_back(awid_q[p].pop_front());
            void'(wlen_q.pop_front()); void'(wport_q.pop_front());
            in_beat = 0; w_beat = 0;
          end else begin
            in_beat++; w_beat++;
          end
          w_v = 0;
        end
        if (dn_b_valid_i[p] && dn_b_ready_o[p]) begin
          void'(bq[p].pop_front()); b_v[p] = 0;
        end
      end
      if (prev_wait)
        check(up_b_valid_o && up_b_id_o == prev_id, "R9 b hold", int'(up_b_id_o), int'(prev_id));
      prev_wait = up_b_valid_o && !up_b_ready_i;
      prev_id = up_b_id_o;
      if (up_b_valid_o && up_b_ready_i) begin
        check(out_cnt[up_b_id_o] > 0, "R8 b id outstanding", out_cnt[up_b_id_o], 1);
        check(up_b_resp_o == up_b_id_o[1:0], "R8 b resp", int'(up_b_resp_o), int'(up_b_id_o[1:0]));
        if (out_cnt[up_b_id_o] > 0) out_cnt[up_b_id_o]--;
        bseq.push_back(int'(up_b_id_o));
      end
    end
  end

  task automatic send_aw(int id, int sel, int len);
    while (aw_pend) @(posedge clk_i);
    @(posedge clk_i);
    n_id = IDW'(id); n_sel = 2'(sel); n_len = 8'(len); aw_pend = 1;
  endtask

  task automatic expect_stall(int n, string req);
    repeat (n) @(posedge clk_i);
    check(aw_pend == 1, req, 0, 1);
  endtask

  task automatic expect_accept(int n, string req);
    int k = 0;
    while (aw_pend && k < n) begin @(posedge clk_i); k++; end
    check(aw_pend == 0, req, int'(aw_pend), 0);
  endtask

  task automatic drain();
    int k = 0;
    int busy = 1;
    while (busy && k < 3000) begin
      @(posedge clk_i); k++;
      busy = aw_pend || wlen_q.size() > 0;
      for (int p = 0; p < NP; p++) if (bq[p].size() > 0) busy = 1;
      for (int i = 0; i < 16; i++) if (out_cnt[i] != 0) busy = 1;
    end
    check(!busy, "R8 drain all responses", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #5;
    check(dn_aw_valid_o == 0 && dn_w_valid_o == 0 && up_b_valid_o == 0 && up_w_ready_o == 0,
          "R10 reset outputs", int'({dn_aw_valid_o, dn_w_valid_o}), 0);
    rst_ni = 1;
    repeat (2) @(posedge clk_i);
    #5;
    check(dn_aw_valid_o == 0 && dn_w_valid_o == 0 && up_b_valid_o == 0 && up_w_ready_o == 0,
          "R10 idle after reset", int'({dn_aw_valid_o, dn_w_valid_o}), 0);

    // R4: fill the open-burst counter to 15
    w_go = 0; b_go = 0;
    for (int i = 0; i < 15; i++) begin
      send_aw(i % 4, 2, 1);
      expect_accept(10, "R4 fill counter");
    end
    send_aw(0, 2, 0);
    expect_stall(10, "R4 saturated counter stalls");
    w_go = 1; b_go = 1;
    expect_accept(40, "R4 resumes after w drain");
    drain();

    // R3: different port while a burst is open
    w_go = 0;
    send_aw(1, 0, 2);
    expect_accept(10, "R3 first aw");
    send_aw(6, 0, 1);
    expect_accept(10, "R3 same port proceeds");
    send_aw(2, 1, 0);
    expect_stall(10, "R3 cross-port stall");
    w_go = 1;
    expect_accept(40, "R3 accepted after drain");
    drain();

    // R5: per-ID limit
    b_go = 0;
    for (int i = 0; i < 8; i++) begin
      send_aw(3, 1, 0);
      expect_accept(20, "R5 fill id entry");
    end
    repeat (20) @(posedge clk_i);
    send_aw(3, 1, 0);
    expect_stall(10, "R5 full id stalls");
    b_go = 1;
    expect_accept(40, "R5 resumes after response");
    drain();

    // R6 / R7: ID port conflict, aliasing, free ID
    b_go = 0;
    send_aw(1, 0, 1);
    expect_accept(10, "R6 first aw");
    repeat (20) @(posedge clk_i);
    send_aw(5, 2, 0);
    expect_stall(10, "R7 alias id stalls");
    b_go = 1;
    expect_accept(40, "R7 alias released");
    drain();
    b_go = 0;
    send_aw(1, 0, 0);
    expect_accept(10, "R6 setup");
    repeat (20) @(posedge clk_i);
    send_aw(1, 3, 0);
    expect_stall(10, "R6 other port stalls");
    b_go = 1;
    expect_accept(40, "R6 released");
    drain();
    b_go = 0;
    send_aw(1, 0, 0);
    expect_accept(10, "R6 setup2");
    repeat (20) @(posedge clk_i);
    send_aw(2, 3, 0);
    expect_accept(10, "R6 free id proceeds");
    repeat (20) @(posedge clk_i);
    send_aw(1, 0, 0);
    expect_accept(10, "R6 same port proceeds");
    b_go = 1;
    drain();

    // R8: round-robin between two backlogged ports
    ub_pct = 0;
    send_aw(0, 0, 0); send_aw(0, 0, 0); send_aw(1, 1, 0); send_aw(1, 1, 0);
    expect_accept(40, "R8 setup");
    repeat (40) @(posedge clk_i);
    bseq.delete();
    ub_pct = 100;
    repeat (20) @(posedge clk_i);
    check(bseq.size() == 4, "R8 response count", bseq.size(), 4);
    for (int i = 0; i + 1 < bseq.size(); i++)
      check(bseq[i] != bseq[i + 1], "R8 round-robin alternation", bseq[i + 1], 1 - bseq[i]);
    drain();

    // random traffic
    aw_pct = 60; wr_pct = 60; ub_pct = 60; w_pct = 70; braise_pct = 50;
    rand_on = 1;
    repeat (4000) @(posedge clk_i);
    rand_on = 0;
    drain();
    for (int p = 0; p < NP; p++)
      check(got_beats[p] == exp_beats[p], "R2 per-port beat total", got_beats[p], exp_beats[p]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule